// File: doc/BRIEF.md
# Multiplexed Address/Data Parallel Port

This block is one byte-wide port of a small microcontroller. Each pin is either a general-purpose I/O bit, owned by a per-bit storage latch that the processor writes, or a line of the external-memory bus, owned by the bus controller while its take-over input is high. The processor can read back two different values. The first is the stored latch byte, which is the correct source for read-modify-write sequences. The second is the level actually present on the pins, after a two-stage synchroniser.

A parameter selects one of two flavours. The low-byte flavour behaves as open-drain in general-purpose mode: a stored 1 releases the pin and a stored 0 pulls it low. On the bus it carries multiplexed address and data, and it releases the pins while data is coming in. Whenever the bus owns the port, its latch is overwritten with ones. The high-byte flavour has a pull-up behind each released pin. On the bus it always drives the upper address byte, and its latch survives bus ownership unchanged, so the stored value returns to the pins when the bus lets go.

Pins are modelled as three vectors per bit: output value, output enable and pull-up enable, plus a sampled input. The processor interface is a set of plain strobes. A read returns its byte with a one-cycle `cpu_rvalid` pulse. There is no back-pressure: the processor must take the byte in that cycle.

Top module: `mux_port`

## Requirements
- R1: After reset every latch bit is 1; the low-byte flavour drives no pin (pin_oe = 0, pin_pu = 0), and the high-byte flavour drives no pin and enables every pull-up (pin_pu all ones).
- R2: A cycle with cpu_wr high and the bus not forcing the latch stores cpu_wdata into the latch at that clock edge.
- R3: A cycle with cpu_rd_latch high makes cpu_rvalid high in the following cycle, with cpu_rdata equal to the latch value at the strobe edge.
- R4: A cycle with cpu_rd_pin high (and cpu_rd_latch low) returns the pin level as it was two clock edges before the strobe edge, through the same one-cycle response.
- R5: If both read strobes are high in the same cycle, the latch value is returned.
- R6: Low-byte flavour, bus idle: a latch bit of 0 gives pin_oe = 1 with pin_out = 0, and a latch bit of 1 gives pin_oe = 0; a pin is never driven high and pin_pu stays 0.
- R7: High-byte flavour, bus idle: a latch bit of 0 gives pin_oe = 1 with pin_out = 0, and a latch bit of 1 gives pin_oe = 0 with pin_pu = 1.
- R8: While bus_own is high with bus_drive high, every pin is driven (pin_oe all ones) with pin_out = bus_ad, and no pull-up is enabled.
- R9: While bus_own is high with bus_drive low, the low-byte flavour releases every pin (pin_oe = 0), while the high-byte flavour still drives bus_ad on every pin.
- R10: Low-byte flavour: every clock edge with bus_own high loads all ones into the latch, even if cpu_wr is high in the same cycle.
- R11: High-byte flavour: bus_own does not change the latch; a cpu_wr during bus ownership is stored; once bus_own falls, the pins follow the latch again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Write strobe for the latch |
| cpu_wdata | input | WIDTH | Byte to store |
| cpu_rd_latch | input | 1 | Request the latch value |
| cpu_rd_pin | input | 1 | Request the synchronised pin level |
| cpu_rdata | output | WIDTH | Read response byte |
| cpu_rvalid | output | 1 | Response valid, one cycle, no back-pressure |
| bus_own | input | 1 | Bus controller owns the pins |
| bus_ad | input | WIDTH | Address/data byte from the bus controller |
| bus_drive | input | 1 | Direction hint: 1 = bus drives the pins, 0 = data phase coming in |
| pin_in | input | WIDTH | Sampled pad levels |
| pin_out | output | WIDTH | Pad output values |
| pin_oe | output | WIDTH | Pad output enables |
| pin_pu | output | WIDTH | Pad pull-up enables |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a processor write and the bus take-over. The bench raises cpu_wr in a cycle where bus_own is already high. It then expects all ones from a later latch read on the low-byte instance and the written byte on the high-byte instance. The second pair is the two read paths: both read strobes are raised together while an external pull-down holds some released pins low, so the latch and pin values differ, and the response must be the latch value.

// File: rtl/mux_port_pkg.sv
package mux_port_pkg;
  typedef enum logic {
    FLAV_LOW_BYTE  = 1'b0,
    FLAV_HIGH_BYTE = 1'b1
  } port_flavour_e;
endpackage

// File: rtl/mux_port_latch.sv
module mux_port_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             force_ones,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)          q <= '1;
    else if (force_ones) q <= '1;
    else if (wr_en)      q <= wr_data;
  end

  AST_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    force_ones |=> (q == {WIDTH{1'b1}})); // R10
  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !force_ones) |=> (q == $past(wr_data))); // R2
endmodule

// File: rtl/mux_port_pad.sv
module mux_port_pad
  import mux_port_pkg::*;
#(
  parameter int            WIDTH   = 8,
  parameter port_flavour_e FLAVOUR = FLAV_LOW_BYTE
) (
  input  logic [WIDTH-1:0] latch_q,
  input  logic             bus_own,
  input  logic             bus_drive,
  input  logic [WIDTH-1:0] bus_ad,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);
  generate
    if (FLAVOUR == FLAV_LOW_BYTE) begin : g_open_drain
      always_comb begin
        if (bus_own) begin
          pad_out = bus_ad;
          pad_oe  = bus_drive ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
        end else begin
          pad_out = '0;
          pad_oe  = ~latch_q;
        end
        pad_pu = '0;
      end
    end else begin : g_pulled_up
      always_comb begin
        if (bus_own) begin
          pad_out = bus_ad;
          pad_oe  = '1;
          pad_pu  = '0;
        end else begin
          pad_out = '0;
          pad_oe  = ~latch_q;
          pad_pu  = latch_q;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mux_port_rdpath.sv
module mux_port_rdpath #(
  parameter int WIDTH      = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_latch,
  input  logic             rd_pin,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid
);
  logic [WIDTH-1:0] sync_q [SYNC_STAGE];

  generate
    for (genvar s = 0; s < SYNC_STAGE; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[s] <= '0;
        else if (s == 0) sync_q[s] <= pin_raw;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_latch | rd_pin;
      if (rd_latch)    rdata <= latch_q;
      else if (rd_pin) rdata <= sync_q[SYNC_STAGE-1];
    end
  end

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_latch || rd_pin) |=> rvalid); // R3
  AST_LATCH_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch |=> (rdata == $past(latch_q))); // R5
endmodule

// File: rtl/mux_port.sv
module mux_port
  import mux_port_pkg::*;
#(
  parameter int            WIDTH   = 8,
  parameter port_flavour_e FLAVOUR = FLAV_LOW_BYTE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic [WIDTH-1:0] cpu_wdata,
  input  logic             cpu_rd_latch,
  input  logic             cpu_rd_pin,
  output logic [WIDTH-1:0] cpu_rdata,
  output logic             cpu_rvalid,
  input  logic             bus_own,
  input  logic [WIDTH-1:0] bus_ad,
  input  logic             bus_drive,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_pu
);
  localparam bit FORCE_ON_BUS = (FLAVOUR == FLAV_LOW_BYTE);

  logic [WIDTH-1:0] latch_q;
  logic             force_ones;

  assign force_ones = FORCE_ON_BUS & bus_own;

  mux_port_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .wr_data(cpu_wdata),
    .force_ones(force_ones), .q(latch_q)
  );

  mux_port_pad #(.WIDTH(WIDTH), .FLAVOUR(FLAVOUR)) u_pad (
    .latch_q(latch_q), .bus_own(bus_own), .bus_drive(bus_drive),
    .bus_ad(bus_ad), .pad_out(pin_out), .pad_oe(pin_oe), .pad_pu(pin_pu)
  );

  mux_port_rdpath #(.WIDTH(WIDTH), .SYNC_STAGE(2)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_latch(cpu_rd_latch), .rd_pin(cpu_rd_pin),
    .latch_q(latch_q), .pin_raw(pin_in), .rdata(cpu_rdata), .rvalid(cpu_rvalid)
  );

  AST_BUS_PUSHPULL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_own && bus_drive) |-> (pin_oe == {WIDTH{1'b1}} && pin_out == bus_ad && pin_pu == '0)); // R8

  generate
    if (FLAVOUR == FLAV_LOW_BYTE) begin : g_chk_low
      AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own |-> ((pin_oe & pin_out) == '0 && pin_pu == '0)); // R6
      AST_LOW_RELEASE_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own && !bus_drive) |-> (pin_oe == '0)); // R9
    end else begin : g_chk_high
      AST_HIGH_LATCH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own && !cpu_wr) |=> $stable(latch_q)); // R11
      AST_HIGH_ADDR_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |-> (pin_oe == {WIDTH{1'b1}} && pin_out == bus_ad)); // R9
    end
  endgenerate
endmodule

// File: tb/mux_port_tb.sv
module mux_port_tb;
  import mux_port_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0, cpu_rd_latch = 1'b0, cpu_rd_pin = 1'b0;
  logic [W-1:0] cpu_wdata = '0;
  logic bus_own = 1'b0, bus_drive = 1'b0;
  logic [W-1:0] bus_ad = '0;
  logic [W-1:0] ext_low = '0;

  logic [W-1:0] lo_rdata, lo_out, lo_oe, lo_pu, lo_pin;
  logic [W-1:0] hi_rdata, hi_out, hi_oe, hi_pu, hi_pin;
  logic lo_rvalid, hi_rvalid;

  int checks = 0;
  int fails = 0;

  logic [W-1:0] lo_q[$];
  logic [W-1:0] hi_q[$];
  string tag_lo[$];
  string tag_hi[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // external pull-up on each pin, overridden by a pull-down mask or a driving pad
  assign lo_pin = (lo_oe & lo_out) | (~lo_oe & ~ext_low);
  assign hi_pin = (hi_oe & hi_out) | (~hi_oe & ~ext_low);

  mux_port #(.WIDTH(W), .FLAVOUR(FLAV_LOW_BYTE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd_latch(cpu_rd_latch), .cpu_rd_pin(cpu_rd_pin),
    .cpu_rdata(lo_rdata), .cpu_rvalid(lo_rvalid),
    .bus_own(bus_own), .bus_ad(bus_ad), .bus_drive(bus_drive),
    .pin_in(lo_pin), .pin_out(lo_out), .pin_oe(lo_oe), .pin_pu(lo_pu)
  );

  mux_port #(.WIDTH(W), .FLAVOUR(FLAV_HIGH_BYTE)) u_dut_hi (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd_latch(cpu_rd_latch), .cpu_rd_pin(cpu_rd_pin),
    .cpu_rdata(hi_rdata), .cpu_rvalid(hi_rvalid),
    .bus_own(bus_own), .bus_ad(bus_ad), .bus_drive(bus_drive),
    .pin_in(hi_pin), .pin_out(hi_out), .pin_oe(hi_oe), .pin_pu(hi_pu)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input bit lat, input bit pin,
                         input logic [W-1:0] e_lo, input logic [W-1:0] e_hi,
                         input string tag);
    @(negedge clk);
    cpu_rd_latch = lat;
    cpu_rd_pin   = pin;
    lo_q.push_back(e_lo); tag_lo.push_back({tag, " low"});
    hi_q.push_back(e_hi); tag_hi.push_back({tag, " high"});
    @(negedge clk);
    cpu_rd_latch = 1'b0;
    cpu_rd_pin   = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [W-1:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  // monitor: pops one expected byte per response pulse
  always @(negedge clk) begin
    if (rst_n && lo_rvalid) begin
      if (lo_q.size() == 0) chk("R3 unexpected low response", 1'b1, 1'b0);
      else chk(tag_lo.pop_front(), lo_rdata, lo_q.pop_front());
    end
    if (rst_n && hi_rvalid) begin
      if (hi_q.size() == 0) chk("R3 unexpected high response", 1'b1, 1'b0);
      else chk(tag_hi.pop_front(), hi_rdata, hi_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] mask;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 low oe", lo_oe, 8'h00);
    chk("R1 low pu", lo_pu, 8'h00);
    chk("R1 high oe", hi_oe, 8'h00);
    chk("R1 high pu", hi_pu, 8'hFF);
    do_read(1, 0, 8'hFF, 8'hFF, "R1 R3 reset latch");

    // R2 write then read back
    do_write(8'h5A);
    do_read(1, 0, 8'h5A, 8'h5A, "R2 R3 latch readback");
    @(negedge clk);
    chk("R6 low oe", lo_oe, 8'hA5);
    chk("R6 low never high", lo_oe & lo_out, 8'h00);
    chk("R6 low pu", lo_pu, 8'h00);
    chk("R7 high oe", hi_oe, 8'hA5);
    chk("R7 high out", hi_oe & hi_out, 8'h00);
    chk("R7 high pu", hi_pu, 8'h5A);

    // R4 pins pulled low externally on released bits
    ext_low = 8'h0F;
    mask = 8'h5A & ~8'h0F;
    repeat (3) @(negedge clk);
    do_read(0, 1, mask, mask, "R4 pin read");
    // R5 both strobes: latch wins although pins differ
    do_read(1, 1, 8'h5A, 8'h5A, "R5 latch over pin");
    do_read(1, 0, 8'h5A, 8'h5A, "R4 latch untouched by pin pull");
    ext_low = 8'h00;
    repeat (3) @(negedge clk);
    do_read(0, 1, 8'h5A, 8'h5A, "R4 pin read released");

    // R8 / R10 / R11 bus take-over with a same-cycle write
    @(negedge clk);
    bus_own = 1'b1; bus_drive = 1'b1; bus_ad = 8'hC3;
    #1;
    chk("R8 low oe", lo_oe, 8'hFF);
    chk("R8 low out", lo_out, 8'hC3);
    chk("R8 high oe", hi_oe, 8'hFF);
    chk("R8 high out", hi_out, 8'hC3);
    chk("R8 high pu", hi_pu, 8'h00);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wdata = 8'h12;
    @(negedge clk);
    cpu_wr = 1'b0;
    // R9 data phase inbound
    bus_drive = 1'b0; bus_ad = 8'h99;
    #1;
    chk("R9 low released", lo_oe, 8'h00);
    chk("R9 high still drives", hi_oe, 8'hFF);
    chk("R9 high out", hi_out, 8'h99);
    repeat (3) @(negedge clk);
    do_read(1, 0, 8'hFF, 8'h12, "R10 R11 latch during bus");
    @(negedge clk);
    bus_own = 1'b0; bus_drive = 1'b0;
    #1;
    chk("R11 high oe after bus", hi_oe, 8'hED);
    chk("R11 high pu after bus", hi_pu, 8'h12);
    chk("R10 low oe after bus", lo_oe, 8'h00);
    do_read(1, 0, 8'hFF, 8'h12, "R10 R11 latch after bus");

    // R2 another pattern
    do_write(8'h81);
    do_read(1, 0, 8'h81, 8'h81, "R2 second pattern");
    repeat (4) @(negedge clk);
    chk("R3 queue drained low", 8'(lo_q.size()), 8'd0);
    chk("R3 queue drained high", 8'(hi_q.size()), 8'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule